// File: doc/BRIEF.md
# Three-Decade Decimal Event Counter with Holding Latches

This block counts events on an external, asynchronous count line and presents the running total as three BCD digits (units, tens, hundreds), covering 000 to 999. The count line is brought into the system clock domain by a short flop chain. Each high-to-low transition of that line is one counting event. All three decades step together on the same system clock edge, so a carry such as 099 to 100 appears in one cycle with no ripple. A one-cycle overflow strobe marks each wrap from 999 to 000. That strobe can drive the count line of a further counter to extend the range.

Each decade drives its own four-bit holding stage. With the latch control low, the outputs follow the counter. With it high, the outputs freeze on the last reading taken while the control was low, and counting carries on underneath. A disable input blocks counting events without losing the total. A synchronous master reset clears the decades. A held reading is not touched by master reset, so a value captured before a reset can still be read after it.

Top module: `bcd_event_counter`

## Requirements
- R1: A falling edge on `count_in` adds exactly one to the count, and a rising edge adds nothing. After `count_in` is sampled low following a high level, the new total is visible on `digits_o` on the third rising clock edge, with the latch control low.
- R2: Each decade runs 0 to 9 and returns to 0. A decade carries into the next one only on its own 9-to-0 step, and every carry lands on the same clock edge as the event that caused it (for example 009 to 010 and 099 to 100). `digits_o[3:0]` holds units, `[7:4]` tens and `[11:8]` hundreds. Each field is plain BCD.
- R3: While `count_dis_i` is high, falling edges on `count_in` leave the count unchanged. After it returns low, counting resumes from the retained total.
- R4: `mreset_i` high at a rising clock edge clears all decades to 000. It takes priority over a counting event on the same edge, and `overflow_o` stays low on that edge.
- R5: While `latch_en_i` is low, `digits_o` equals the counter value on every cycle, including the cycle in which the counter changes.
- R6: While `latch_en_i` is high, `digits_o` holds the counter value from the last clock edge at which `latch_en_i` was low, and counting events still advance the counter. When `latch_en_i` returns low, `digits_o` shows the advanced count.
- R7: A master reset applied while `latch_en_i` stays high leaves `digits_o` unchanged. Once `latch_en_i` goes low, `digits_o` shows 000.
- R8: `overflow_o` is high for exactly one clock cycle on the event that wraps 999 to 000. That is the same cycle in which `digits_o` first shows 000. It is low at all other times, giving one strobe per 1000 events.
- R9: `rst_n` low clears the counter, the held outputs, the synchroniser and `overflow_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 1 | Asynchronous count line; each falling edge is one event |
| count_dis_i | input | 1 | High blocks counting events, keeps the total |
| latch_en_i | input | 1 | Low: outputs follow the counter; high: outputs hold |
| mreset_i | input | 1 | Synchronous active-high clear of the decades |
| digits_o | output | 4*NUM_DIGITS | Held BCD digits, units in the lowest nibble |
| overflow_o | output | 1 | One-cycle strobe on each 999-to-000 wrap |

## Verification
The assertions check several things on every cycle. Each decade stays within 0 to 9 and its next value is correct for its enable. Disable and clear act on the decades. The outputs follow or hold according to the latch control. The overflow strobe is single-cycle and coincides with an all-zero counter. Other behaviour shows up only in the bench's scenarios. The bench sweeps a full 1000-event cycle against an arithmetic model, so every carry pattern and the wrap are covered. It measures the three-edge latency and shows that rising edges are not counted. It also runs the master-reset-during-hold sequence and the case where a reset collides with an event at 999.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_ZERO = 4'd0;
    localparam bcd_t BCD_MAX  = 4'd9;
endpackage

// File: rtl/bcdc_edge_sync.sv
module bcdc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic fall_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_state_t;

    sync_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[TOP-1:0], sig_in};
        nxt_d.last  = cur_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign fall_o = cur_q.last & ~cur_q.chain[TOP];

    // R1
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/bcdc_decade.sv
module bcdc_decade
    import bcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output bcd_t digit_o,
    output bcd_t digit_next_o,
    output logic nine_o
);
    typedef struct packed {
        bcd_t digit;
    } dec_state_t;

    dec_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear_i) begin
            nxt_d.digit = BCD_ZERO;
        end else if (step_i) begin
            if (cur_q.digit == BCD_MAX) nxt_d.digit = BCD_ZERO;
            else                        nxt_d.digit = bcd_t'(cur_q.digit + 4'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign digit_o      = cur_q.digit;
    assign digit_next_o = nxt_d.digit;
    assign nine_o       = (cur_q.digit == BCD_MAX);

    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_o <= BCD_MAX);
    // R2
    roll_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && digit_o == BCD_MAX) |=> digit_o == BCD_ZERO);
    // R1
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && digit_o != BCD_MAX) |=> digit_o == bcd_t'($past(digit_o) + 4'd1));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(digit_o));
    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> digit_o == BCD_ZERO);
endmodule

// File: rtl/bcdc_hold_stage.sv
module bcdc_hold_stage
    import bcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  bcd_t din_i,
    output bcd_t dout_o
);
    typedef struct packed {
        bcd_t val;
    } hold_state_t;

    hold_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!hold_i) nxt_d.val = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dout_o = cur_q.val;

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(dout_o));
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
    import bcdc_pkg::*;
#(
    parameter int NUM_DIGITS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        count_in,
    input  logic                        count_dis_i,
    input  logic                        latch_en_i,
    input  logic                        mreset_i,
    output logic [BCD_W*NUM_DIGITS-1:0] digits_o,
    output logic                        overflow_o
);
    localparam int FLAT_W = BCD_W * NUM_DIGITS;

    typedef struct packed {
        logic ovf;
    } top_state_t;

    logic                  fall_evt;
    logic [NUM_DIGITS:0]   enable_chain;
    logic [NUM_DIGITS-1:0] nine_vec;
    bcd_t                  cnt_now  [NUM_DIGITS];
    bcd_t                  cnt_next [NUM_DIGITS];
    logic [FLAT_W-1:0]     cnt_flat;
    top_state_t            cur_q, nxt_d;

    bcdc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (count_in),
        .fall_o (fall_evt)
    );

    assign enable_chain[0] = fall_evt & ~count_dis_i;

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
        bcdc_decade u_decade (
            .clk          (clk),
            .rst_n        (rst_n),
            .clear_i      (mreset_i),
            .step_i       (enable_chain[gi]),
            .digit_o      (cnt_now[gi]),
            .digit_next_o (cnt_next[gi]),
            .nine_o       (nine_vec[gi])
        );

        assign enable_chain[gi+1] = enable_chain[gi] & nine_vec[gi];
        assign cnt_flat[gi*BCD_W +: BCD_W] = cnt_now[gi];

        bcdc_hold_stage u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (latch_en_i),
            .din_i  (cnt_next[gi]),
            .dout_o (digits_o[gi*BCD_W +: BCD_W])
        );
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ovf = enable_chain[NUM_DIGITS] & ~mreset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign overflow_o = cur_q.ovf;

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> cnt_flat == '0);
    // R8
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> !overflow_o);
    // R4
    mreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_i |=> (cnt_flat == '0 && !overflow_o));
    // R3
    disable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_dis_i && !mreset_i) |=> $stable(cnt_flat));
    // R5
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en_i |=> digits_o == cnt_flat);
endmodule

// File: tb/bcd_event_counter_tb.sv
`timescale 1ns/1ps
module bcd_event_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_in = 1'b0;
    logic        count_dis_i = 1'b0;
    logic        latch_en_i = 1'b0;
    logic        mreset_i = 1'b0;
    logic [11:0] digits_o;
    logic        overflow_o;

    int total = 0;
    int bad = 0;
    int expv = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bcd_event_counter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_in    (count_in),
        .count_dis_i (count_dis_i),
        .latch_en_i  (latch_en_i),
        .mreset_i    (mreset_i),
        .digits_o    (digits_o),
        .overflow_o  (overflow_o)
    );

    function automatic logic [11:0] to_bcd(int v);
        return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expd);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
        end
    endtask

    task automatic check_digits(input string req, input int v);
        check(digits_o == to_bcd(v), req, int'(digits_o), int'(to_bcd(v)));
    endtask

    // returns at the negedge just after the update edge (third edge after low is sampled)
    task automatic count_event();
        count_in = 1'b1;
        tick(); tick();
        count_in = 1'b0;
        tick(); tick(); tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R9 reset state
        check_digits("R9", 0);
        check(overflow_o == 1'b0, "R9", overflow_o, 0);
        rst_n = 1'b1;
        tick();

        // R1 rising edge alone does nothing
        count_in = 1'b1;
        repeat (5) tick();
        check_digits("R1 rise", 0);
        // R1 latency: unchanged after two edges, new after three
        count_in = 1'b0;
        tick(); tick();
        check_digits("R1 early", 0);
        tick();
        check_digits("R1 latency", 1);
        expv = 1;

        // R1 R2 R8 full sweep through the wrap
        for (int k = 0; k < 999; k++) begin
            count_event();
            expv = (expv + 1) % 1000;
            if (expv == 10 || expv == 100 || expv == 110 || expv == 0)
                check_digits("R2 carry", expv);
            else
                check_digits("R1 sweep", expv);
            check(overflow_o == (expv == 0), "R8 strobe", overflow_o, int'(expv == 0));
        end
        tick();
        check(overflow_o == 1'b0, "R8 one cycle", overflow_o, 0);

        // R3 disable
        count_event();
        expv = 1;
        count_dis_i = 1'b1;
        for (int k = 0; k < 5; k++) count_event();
        check_digits("R3 blocked", expv);
        count_dis_i = 1'b0;
        tick();
        count_event();
        expv++;
        check_digits("R3 resume", expv);

        // R6 hold while counting continues, R5 follow after release
        latch_en_i = 1'b1;
        for (int k = 0; k < 4; k++) count_event();
        check_digits("R6 held", expv);
        expv += 4;
        latch_en_i = 1'b0;
        tick();
        check_digits("R5 follow", expv);

        // R4 master reset with outputs following
        mreset_i = 1'b1;
        tick();
        mreset_i = 1'b0;
        check_digits("R4 clear", 0);
        expv = 0;

        // R7 held value survives reset
        for (int k = 0; k < 7; k++) count_event();
        expv = 7;
        check_digits("R5 count", expv);
        latch_en_i = 1'b1;
        tick();
        mreset_i = 1'b1;
        tick(); tick();
        mreset_i = 1'b0;
        tick();
        check_digits("R7 kept", 7);
        latch_en_i = 1'b0;
        tick();
        check_digits("R7 after", 0);
        expv = 0;

        // R4 priority over an event at 999
        for (int k = 0; k < 999; k++) count_event();
        expv = 999;
        check_digits("R4 at 999", expv);
        check(overflow_o == 1'b0, "R8 no strobe", overflow_o, 0);
        count_in = 1'b1;
        tick(); tick();
        count_in = 1'b0;
        tick(); tick();
        mreset_i = 1'b1;
        tick();
        mreset_i = 1'b0;
        check_digits("R4 priority", 0);
        check(overflow_o == 1'b0, "R4 no overflow", overflow_o, 0);
        count_event();
        check_digits("R4 restart", 1);

        // R9 asynchronous reset clears held outputs too
        latch_en_i = 1'b1;
        rst_n = 1'b0;
        tick();
        check_digits("R9 async", 0);
        rst_n = 1'b1;
        latch_en_i = 1'b0;
        tick();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule